// File: doc/BRIEF.md
# Timer Output Mode Selector

This block produces the single output pin of a timer. A small mode register picks what drives the pin. Seven sources are available, plus one reserved code:

- an output flip-flop that inverts on every compare-match strobe;
- a burst-generator signal gated by that flip-flop;
- the same burst signal gated by a serial data bit;
- the serial bit coded as Manchester;
- the serial bit coded as Bi-phase;
- the serial bit passed straight through;
- an external PWM signal.

The counter, the burst generator and the PWM generator sit outside the block and arrive as input signals.

Software writes the 4-bit mode register through a one-cycle write strobe. Bit 3 of the written value presets the output flip-flop. The preset is refused while the timer-run flag is high. The line coders take the compare strobe as their half-bit clock. The pin itself is a register, so it moves only on clock edges and carries no glitches.

Top module: `tmr_out_sel`

## Requirements
- R1: After reset the mode register holds 4'b1111, which selects toggle mode. The output flip-flop, the coder state and `pin_out` are all 0.
- R2: Select code 3'b111 (bits 2..0 of the mode register) is toggle mode. Each `cmp_hit` cycle inverts the output flip-flop, and the flip-flop drives the pin.
- R3: A write with `tmr_run` low loads bit 3 of `cfg_wdata` into the output flip-flop. A 1 sets it and a 0 clears it. The preset wins over a compare strobe in the same cycle.
- R4: A write with `tmr_run` high leaves the output flip-flop unchanged, but the select bits are still written.
- R5: Select 3'b110 drives the pin with `burst_in` AND the output flip-flop.
- R6: Select 3'b101 drives the pin with `burst_in` AND `ser_bit`.
- R7: Select 3'b010 drives the pin with `ser_bit`.
- R8: Select 3'b001 drives the pin with `pwm_in`.
- R9: Select 3'b000 is reserved and holds the pin at 0.
- R10: Select 3'b011 gives Manchester coding.
  - A phase flag inverts on every `cmp_hit`.
  - When the flag moves from 1 to 0, a bit boundary is taken and `ser_bit` is captured.
  - The pin is the captured bit XOR the phase.
- R11: Select 3'b100 gives Bi-phase coding, using the same phase flag and bit boundaries as R10.
  - The coder level inverts at every bit boundary.
  - At mid-bit (the flag moving from 0 to 1) it also inverts, but only when the captured bit is 1.
- R12: `pin_out` is registered. A change at an input or a coder state shows on the pin one clock edge after it takes effect. A change in mode therefore shows two edges after the write strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmp_hit | input | 1 | Compare-match strobe, one cycle per match |
| burst_in | input | 1 | Burst-generator signal |
| ser_bit | input | 1 | Serial data bit |
| pwm_in | input | 1 | PWM signal |
| tmr_run | input | 1 | Timer-run flag; blocks the preset when high |
| cfg_we | input | 1 | Mode register write strobe |
| cfg_wdata | input | 4 | Write data: bit 3 preset value, bits 2..0 select |
| pin_out | output | 1 | Timer output pin |

## Verification
The assertions run on every cycle and cover the cycle-level relations:

- a compare strobe inverts the flip-flop;
- a preset lands when the timer is stopped and is refused while it runs;
- the coder captures the serial bit at each bit boundary;
- pass-through mode and the reserved code drive the pin one edge later.

Only the directed scenarios can show the multi-pulse waveforms of the Manchester and Bi-phase coders and the gating in the two burst modes. They also confirm that the reset value of the mode register selects toggle mode.

// File: rtl/tos_pkg.sv
package tos_pkg;
  localparam int SEL_W = 3;
  localparam int CFG_W = SEL_W + 1;
  localparam logic [CFG_W-1:0] CFG_RST = '1;

  typedef enum logic [SEL_W-1:0] {
    SEL_OFF = 3'b000,
    SEL_PWM = 3'b001,
    SEL_SER = 3'b010,
    SEL_MAN = 3'b011,
    SEL_BPH = 3'b100,
    SEL_BRS = 3'b101,
    SEL_BRT = 3'b110,
    SEL_TGL = 3'b111
  } sel_e;
endpackage

// File: rtl/tos_rst_sync.sv
module tos_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_s
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_s = sh_q[STAGES-1];
endmodule

// File: rtl/tos_cfg_reg.sv
module tos_cfg_reg
  import tos_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [CFG_W-1:0] wdata,
  output sel_e             sel
);
  logic [CFG_W-1:0] cfg_q, cfg_d;

  always_comb begin
    cfg_d = cfg_q;
    if (we) cfg_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= CFG_RST;
    else        cfg_q <= cfg_d;
  end

  assign sel = sel_e'(cfg_q[SEL_W-1:0]);
endmodule

// File: rtl/tos_tflop.sv
module tos_tflop (
  input  logic clk,
  input  logic rst_n,
  input  logic cmp_hit,
  input  logic we,
  input  logic preset_val,
  input  logic tmr_run,
  output logic tff
);
  logic tff_q, tff_d, preset_ok;

  assign preset_ok = we & ~tmr_run;

  always_comb begin
    tff_d = tff_q;
    if (preset_ok)    tff_d = preset_val;
    else if (cmp_hit) tff_d = ~tff_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tff_q <= 1'b0;
    else        tff_q <= tff_d;
  end

  assign tff = tff_q;

  a_r3_preset_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !tmr_run) |=> (tff == $past(preset_val)));
  a_r4_preset_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (we && tmr_run && !cmp_hit) |=> $stable(tff));
  a_r2_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_hit && !(we && !tmr_run)) |=> (tff != $past(tff)));
endmodule

// File: rtl/tos_coder.sv
module tos_coder (
  input  logic clk,
  input  logic rst_n,
  input  logic cmp_hit,
  input  logic ser_bit,
  output logic man_o,
  output logic bph_o
);
  logic ph_q, ph_d;
  logic dat_q, dat_d;
  logic bp_q, bp_d;
  logic edge_bit, edge_mid;

  assign edge_bit = cmp_hit & ph_q;
  assign edge_mid = cmp_hit & ~ph_q;

  always_comb begin
    ph_d  = ph_q;
    dat_d = dat_q;
    bp_d  = bp_q;
    if (cmp_hit) ph_d = ~ph_q;
    if (edge_bit) begin
      dat_d = ser_bit;
      bp_d  = ~bp_q;
    end else if (edge_mid && dat_q) begin
      bp_d  = ~bp_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= 1'b0;
      dat_q <= 1'b0;
      bp_q  <= 1'b0;
    end else begin
      ph_q  <= ph_d;
      dat_q <= dat_d;
      bp_q  <= bp_d;
    end
  end

  assign man_o = dat_q ^ ph_q;
  assign bph_o = bp_q;

  a_r10_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_hit && ph_q) |=> (!ph_q && dat_q == $past(ser_bit)));
  a_r11_boundary_flip: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_hit && ph_q) |=> (bph_o != $past(bph_o)));
  a_r11_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !cmp_hit |=> ($stable(bph_o) && $stable(man_o)));
endmodule

// File: rtl/tmr_out_sel.sv
module tmr_out_sel
  import tos_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmp_hit,
  input  logic             burst_in,
  input  logic             ser_bit,
  input  logic             pwm_in,
  input  logic             tmr_run,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  output logic             pin_out
);
  logic rst_n_s;
  sel_e sel;
  logic tff, man, bph;
  logic pin_d, pin_q;

  tos_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_s(rst_n_s)
  );

  tos_cfg_reg u_cfg (
    .clk(clk), .rst_n(rst_n_s), .we(cfg_we), .wdata(cfg_wdata), .sel(sel)
  );

  tos_tflop u_tff (
    .clk(clk), .rst_n(rst_n_s), .cmp_hit(cmp_hit), .we(cfg_we),
    .preset_val(cfg_wdata[CFG_W-1]), .tmr_run(tmr_run), .tff(tff)
  );

  tos_coder u_cod (
    .clk(clk), .rst_n(rst_n_s), .cmp_hit(cmp_hit), .ser_bit(ser_bit),
    .man_o(man), .bph_o(bph)
  );

  always_comb begin
    case (sel)
      SEL_TGL: pin_d = tff;
      SEL_BRT: pin_d = burst_in & tff;
      SEL_BRS: pin_d = burst_in & ser_bit;
      SEL_BPH: pin_d = bph;
      SEL_MAN: pin_d = man;
      SEL_SER: pin_d = ser_bit;
      SEL_PWM: pin_d = pwm_in;
      default: pin_d = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) pin_q <= 1'b0;
    else          pin_q <= pin_d;
  end

  assign pin_out = pin_q;

  a_r9_reserved_low: assert property (@(posedge clk) disable iff (!rst_n_s)
    (sel == SEL_OFF) |=> !pin_out);
  a_r7_pass: assert property (@(posedge clk) disable iff (!rst_n_s)
    (sel == SEL_SER) |=> (pin_out == $past(ser_bit)));
  a_r8_pwm: assert property (@(posedge clk) disable iff (!rst_n_s)
    (sel == SEL_PWM) |=> (pin_out == $past(pwm_in)));
endmodule

// File: tb/tmr_out_sel_tb.sv
module tmr_out_sel_tb;
  logic clk = 1'b0;
  logic rst_n, cmp_hit, burst_in, ser_bit, pwm_in, tmr_run, cfg_we;
  logic [3:0] cfg_wdata;
  logic pin_out;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  tmr_out_sel u_dut (
    .clk(clk), .rst_n(rst_n), .cmp_hit(cmp_hit), .burst_in(burst_in),
    .ser_bit(ser_bit), .pwm_in(pwm_in), .tmr_run(tmr_run), .cfg_we(cfg_we),
    .cfg_wdata(cfg_wdata), .pin_out(pin_out)
  );

  task automatic check(input logic exp, input string tag);
    checks++;
    if (pin_out !== exp) begin
      errors++;
      $display("FAIL %s: pin_out=%b expected %b", tag, pin_out, exp);
    end
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; cmp_hit = 0; burst_in = 0; ser_bit = 0; pwm_in = 0;
    tmr_run = 0; cfg_we = 0; cfg_wdata = 4'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] v);
    cfg_wdata = v; cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
    @(negedge clk);
  endtask

  task automatic pulse();
    cmp_hit = 1'b1;
    @(negedge clk);
    cmp_hit = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset();
    check(1'b0, "R1 pin after reset");
    pulse();
    check(1'b1, "R1 default select is toggle");
  endtask

  task automatic t_toggle();
    do_reset();
    pulse(); check(1'b1, "R2 toggle 1");
    pulse(); check(1'b0, "R2 toggle 2");
    pulse(); check(1'b1, "R2 toggle 3");
  endtask

  task automatic t_preset();
    do_reset();
    wr(4'b1111); check(1'b1, "R3 preset set");
    wr(4'b0111); check(1'b0, "R3 preset clear");
    cfg_wdata = 4'b1111; cfg_we = 1'b1; cmp_hit = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0; cmp_hit = 1'b0;
    @(negedge clk);
    check(1'b1, "R3 preset beats strobe");
  endtask

  task automatic t_blocked();
    do_reset();
    tmr_run = 1'b1;
    wr(4'b1111); check(1'b0, "R4 preset ignored while running");
    ser_bit = 1'b1;
    wr(4'b1010); settle(); check(1'b1, "R4 select written while running");
    wr(4'b0111); settle(); check(1'b0, "R4 flop still clear");
    tmr_run = 1'b0; ser_bit = 1'b0;
  endtask

  task automatic t_burst_tff();
    do_reset();
    burst_in = 1'b1;
    wr(4'b1110); settle(); check(1'b1, "R5 burst and flop high");
    burst_in = 1'b0; settle(); check(1'b0, "R5 burst low");
    burst_in = 1'b1;
    wr(4'b0110); settle(); check(1'b0, "R5 flop low gates burst");
  endtask

  task automatic t_burst_ser();
    do_reset();
    wr(4'b0101);
    burst_in = 1'b1; ser_bit = 1'b1; settle(); check(1'b1, "R6 burst and ser");
    ser_bit = 1'b0; settle(); check(1'b0, "R6 ser low gates");
    ser_bit = 1'b1; burst_in = 1'b0; settle(); check(1'b0, "R6 burst low");
  endtask

  task automatic t_pass_pwm_off();
    do_reset();
    wr(4'b0010);
    ser_bit = 1'b1; settle(); check(1'b1, "R7 pass high");
    ser_bit = 1'b0; settle(); check(1'b0, "R7 pass low");
    wr(4'b0001);
    pwm_in = 1'b1; settle(); check(1'b1, "R8 pwm high");
    pwm_in = 1'b0; settle(); check(1'b0, "R8 pwm low");
    pwm_in = 1'b1; ser_bit = 1'b1; burst_in = 1'b1;
    wr(4'b1000); settle(); check(1'b0, "R9 reserved low");
    pulse(); check(1'b0, "R9 reserved low after strobe");
  endtask

  task automatic t_manchester();
    do_reset();
    wr(4'b0011);
    ser_bit = 1'b1;
    check(1'b0, "R10 start");
    pulse(); check(1'b1, "R10 pulse1");
    pulse(); check(1'b1, "R10 pulse2");
    pulse(); check(1'b0, "R10 pulse3");
    ser_bit = 1'b0;
    pulse(); check(1'b0, "R10 pulse4");
    pulse(); check(1'b1, "R10 pulse5");
  endtask

  task automatic t_biphase();
    do_reset();
    wr(4'b0100);
    ser_bit = 1'b1;
    check(1'b0, "R11 start");
    pulse(); check(1'b0, "R11 pulse1");
    pulse(); check(1'b1, "R11 pulse2");
    pulse(); check(1'b0, "R11 pulse3");
    ser_bit = 1'b0;
    pulse(); check(1'b1, "R11 pulse4");
    pulse(); check(1'b1, "R11 pulse5");
    pulse(); check(1'b0, "R11 pulse6");
  endtask

  task automatic t_registered();
    do_reset();
    wr(4'b0010); settle();
    check(1'b0, "R12 before change");
    ser_bit = 1'b1;
    #1 check(1'b0, "R12 no change before edge");
    @(negedge clk); check(1'b1, "R12 after one edge");
  endtask

  initial begin
    rst_n = 1'b0;
    t_reset();
    t_toggle();
    t_preset();
    t_blocked();
    t_burst_tff();
    t_burst_ser();
    t_pass_pwm_off();
    t_manchester();
    t_biphase();
    t_registered();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule